// File: doc/BRIEF.md
# BCD Calendar Clock Counter

The block keeps wall-clock time to one-second resolution. A prescaler counts cycles of the reference clock while the global enable is high. Each time it has counted `REF_PER_SEC` cycles it issues a one-second strobe. The strobe advances a chain of BCD fields: seconds, minutes, hours, day of week, day of month, month and a three-digit year. Rollover covers every calendar boundary, and February's length follows the full Gregorian leap rule applied to the three-digit year.

Software reaches the fields through a small register port with one write path and one combinational read path. The same field select serves both. Writes take effect only while the global enable is high. Every field and the registered one-second strobe are also driven straight out, so a neighbouring alarm unit can compare against them. The strobe is high in the cycle in which the fields already carry the new second.

Top module: `bcd_calendar`

## Requirements
- R1: While `en_i` is high, `tick_o` is a single-cycle pulse on every `REF_PER_SEC`-th rising edge. The first pulse comes on the `REF_PER_SEC`-th edge after `en_i` is sampled high. While `en_i` is low the prescaler is held at zero and no pulse occurs.
- R2: On a strobe, seconds count 00..59 and wrap to 00, carrying into minutes. Minutes count 00..59 and wrap to 00, carrying into hours. Hours count 00..23.
- R3: An hour wrap advances day of week and day of month in the same cycle. Day of week counts 0..6 and then returns to 0.
- R4: The month length in days is 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 or 29 for month 02. Any other month value (00 or above 12) is given 31 days.
- R5: A day-of-month at or above the month length wraps to 01 and advances the month. A month at or above 12 wraps to 01 and advances the year. Year 999 wraps to 000.
- R6: February has 29 days when the year is divisible by 4 and either not divisible by 100 or divisible by 400. Examples: 000 and 400 are leap years, 100 and 200 are not, 004 and 096 are leap years.
- R7: A day-of-month of 00 becomes 01 on the next day rollover, and the month does not advance.
- R8: With `en_i` and `wr_en_i` both high, the field chosen by `wr_sel_i` loads the low bits of `wr_data_i`. The select codes are 0 seconds (7 bits), 1 minutes (7), 2 hours (6), 3 day of week (3), 4 day of month (6), 5 month (5) and 6 year (12, hundreds digit in bits [11:8], tens in [7:4], units in [3:0]). Code 7 writes nothing. A write overrides the same-cycle strobe advance of that field only.
- R9: A write while `en_i` is low changes no field.
- R10: `rd_data_o` returns, zero-extended and in the same cycle, the field chosen by `rd_sel_i` using the codes of R8. Code 7 reads 0.
- R11: After reset the time is 00:00:00, day of week 0, date 01-01, year 000, and `tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable: runs the prescaler and allows writes |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for writes |
| wr_data_i | input | 12 | BCD write data |
| rd_sel_i | input | 3 | Field select for reads |
| rd_data_o | output | 12 | Selected field, zero-extended BCD |
| tick_o | output | 1 | One-second strobe, aligned with the updated fields |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| wday_o | output | 3 | Day of week, 0..6 |
| mday_o | output | 6 | Day of month, BCD |
| mon_o | output | 5 | Month, BCD 01..12 |
| year_o | output | 12 | Year, three BCD digits |

## Verification
Several properties are checked on every cycle. The strobe must match an independent model of the enable-gated prescaler. A pulse must never last two cycles. While the enable is low, every field must stay frozen. The seconds, day-of-week and year-end wraps must happen whenever the fields reach those points without a competing write. Month lengths across leap and century years, the unbroken count through an hour and a day boundary, and the handling of an out-of-range day or month are visible only in the bench's directed sweeps. So are the write-over-strobe priority and the read multiplexer.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned DATA_W     = 12;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_WDAY = 3'd3,
    SEL_MDAY = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_NONE = 3'd7
  } field_sel_e;

  // Per-field storage width, reset/wrap value and wrap threshold (BCD).
  localparam int unsigned FIELD_W [NUM_FIELDS] = '{7, 7, 6, 3, 6, 5, 12};
  localparam logic [DATA_W-1:0] FIELD_BASE [NUM_FIELDS] =
    '{12'h000, 12'h000, 12'h000, 12'h000, 12'h001, 12'h001, 12'h000};
  localparam logic [DATA_W-1:0] FIELD_LIM [NUM_FIELDS] =
    '{12'h059, 12'h059, 12'h023, 12'h006, 12'h031, 12'h012, 12'h999};

  function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int d = 0; d < DATA_W / 4; d++) begin
      if (c) begin
        if (r[d*4+:4] >= 4'd9) begin
          r[d*4+:4] = 4'd0;
        end else begin
          r[d*4+:4] = r[d*4+:4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned REF_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sec_tick_o
);
  localparam int unsigned CW = (REF_PER_SEC > 2) ? $clog2(REF_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (sec_tick_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [4:0]  mon_i,
  input  logic [11:0] year_i,
  output logic [5:0]  len_o
);
  logic [3:0] units, tens, hund;
  logic div4, century, div400, leap;

  assign units = year_i[3:0];
  assign tens  = year_i[7:4];
  assign hund  = year_i[11:8];

  // Divisibility read from the decimal digits directly.
  assign div4    = tens[0] ? (units == 4'd2 || units == 4'd6)
                           : (units == 4'd0 || units == 4'd4 || units == 4'd8);
  assign century = (year_i[7:0] == 8'h00);
  assign div400  = (hund == 4'd0 || hund == 4'd4 || hund == 4'd8);
  assign leap    = div4 && (!century || div400);

  always_comb begin
    unique case (mon_i)
      5'h02:                      len_o = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: len_o = 6'h30;
      default:                    len_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/cal_field.sv
module cal_field #(
  parameter int unsigned WIDTH = 7,
  parameter logic [11:0] BASE  = 12'h000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wrap_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] val_o
);
  import cal_pkg::*;

  logic [WIDTH-1:0] val_q, val_d;
  logic [DATA_W-1:0] stepped;

  assign stepped = bcd_inc(DATA_W'(val_q));

  always_comb begin
    val_d = val_q;
    if (wr_i)        val_d = wr_data_i;
    else if (inc_i)  val_d = wrap_i ? WIDTH'(BASE) : WIDTH'(stepped);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= WIDTH'(BASE);
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int unsigned REF_PER_SEC = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [11:0] wr_data_i,
  input  logic [2:0]  rd_sel_i,
  output logic [11:0] rd_data_o,
  output logic        tick_o,
  output logic [6:0]  sec_o,
  output logic [6:0]  min_o,
  output logic [5:0]  hour_o,
  output logic [2:0]  wday_o,
  output logic [5:0]  mday_o,
  output logic [4:0]  mon_o,
  output logic [11:0] year_o
);
  logic              sec_tick;
  logic              tick_q;
  logic              wr_go;
  logic [5:0]        mday_lim;
  logic [NUM_FIELDS-1:0] inc, at_lim, wr_hit;
  logic [DATA_W-1:0] fld [NUM_FIELDS];
  logic [DATA_W-1:0] lim [NUM_FIELDS];

  cal_prescaler #(.REF_PER_SEC(REF_PER_SEC)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sec_tick_o (sec_tick)
  );

  cal_month_len u_mlen (
    .mon_i  (fld[SEL_MON][4:0]),
    .year_i (fld[SEL_YEAR]),
    .len_o  (mday_lim)
  );

  assign wr_go = en_i && wr_en_i;

  // Carry chain; day of week and day of month share the hour wrap.
  assign inc[0] = sec_tick;
  assign inc[1] = inc[0] && at_lim[0];
  assign inc[2] = inc[1] && at_lim[1];
  assign inc[3] = inc[2] && at_lim[2];
  assign inc[4] = inc[3];
  assign inc[5] = inc[4] && at_lim[4];
  assign inc[6] = inc[5] && at_lim[5];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int unsigned W = FIELD_W[g];
    logic [W-1:0] v;

    if (g == int'(SEL_MDAY)) begin : g_dyn
      assign lim[g] = DATA_W'(mday_lim);
    end else begin : g_fix
      assign lim[g] = FIELD_LIM[g];
    end

    assign at_lim[g] = (fld[g] >= lim[g]);
    assign wr_hit[g] = wr_go && (wr_sel_i == 3'(g));

    cal_field #(.WIDTH(W), .BASE(FIELD_BASE[g])) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc[g]),
      .wrap_i    (at_lim[g]),
      .wr_i      (wr_hit[g]),
      .wr_data_i (wr_data_i[W-1:0]),
      .val_o     (v)
    );

    assign fld[g] = DATA_W'(v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= sec_tick;
  end

  always_comb begin
    unique case (field_sel_e'(rd_sel_i))
      SEL_SEC:  rd_data_o = fld[0];
      SEL_MIN:  rd_data_o = fld[1];
      SEL_HOUR: rd_data_o = fld[2];
      SEL_WDAY: rd_data_o = fld[3];
      SEL_MDAY: rd_data_o = fld[4];
      SEL_MON:  rd_data_o = fld[5];
      SEL_YEAR: rd_data_o = fld[6];
      default:  rd_data_o = '0;
    endcase
  end

  assign tick_o = tick_q;
  assign sec_o  = fld[0][6:0];
  assign min_o  = fld[1][6:0];
  assign hour_o = fld[2][5:0];
  assign wday_o = fld[3][2:0];
  assign mday_o = fld[4][5:0];
  assign mon_o  = fld[5][4:0];
  assign year_o = fld[6];
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int unsigned REF_PER_SEC = 32768
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i,
  input logic        tick_o,
  input logic [6:0]  sec_o,
  input logic [6:0]  min_o,
  input logic [5:0]  hour_o,
  input logic [2:0]  wday_o,
  input logic [5:0]  mday_o,
  input logic [4:0]  mon_o,
  input logic [11:0] year_o
);
  localparam int unsigned CW = (REF_PER_SEC > 2) ? $clog2(REF_PER_SEC) : 1;

  logic [CW-1:0] ref_cnt;
  logic          wr_any;
  logic          end_of_day;
  logic [46:0]   all_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      ref_cnt <= '0;
    else if (!en_i)                                   ref_cnt <= '0;
    else if (ref_cnt == CW'(REF_PER_SEC - 1))         ref_cnt <= '0;
    else                                              ref_cnt <= ref_cnt + 1'b1;
  end

  assign wr_any     = en_i && wr_en_i && (wr_sel_i != 3'd7);
  assign end_of_day = (hour_o == 6'h23) && (min_o == 7'h59) && (sec_o == 7'h59);
  assign all_f      = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};

  AST_TICK_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ref_cnt == CW'(REF_PER_SEC - 1)) |=> tick_o);  // R1

  AST_TICK_EARNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(en_i && ref_cnt == CW'(REF_PER_SEC - 1)));  // R1

  if (REF_PER_SEC > 1) begin : g_pulse
    AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);  // R1
  end

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(all_f));  // R9

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(sec_o == 7'h59 && !wr_any)) |-> (sec_o == 7'h00));  // R2

  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(end_of_day && wday_o == 3'd6 && !wr_any))
      |-> (wday_o == 3'd0 && hour_o == 6'h00));  // R3

  AST_YEAR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(end_of_day && mon_o == 5'h12 && mday_o == 6'h31 && !wr_any))
      |-> (mon_o == 5'h01 && mday_o == 6'h01));  // R5
endmodule

bind bcd_calendar cal_checker #(.REF_PER_SEC(REF_PER_SEC)) u_cal_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .tick_o   (tick_o),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hour_o   (hour_o),
  .wday_o   (wday_o),
  .mday_o   (mday_o),
  .mon_o    (mon_o),
  .year_o   (year_o)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
  localparam int unsigned REF = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [11:0] rd_data;
  logic        tick;
  logic [6:0]  sec, min;
  logic [5:0]  hour, mday;
  logic [2:0]  wday;
  logic [4:0]  mon;
  logic [11:0] year;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar #(.REF_PER_SEC(REF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .tick_o(tick),
    .sec_o(sec), .min_o(min), .hour_o(hour), .wday_o(wday), .mday_o(mday),
    .mon_o(mon), .year_o(year)
  );

  function automatic logic [11:0] bcd(input int v);
    return 12'(((v / 100) % 10) << 8 | ((v / 10) % 10) << 4 | (v % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return ((y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0))) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Fields packed in output order for a single compare.
  function automatic logic [63:0] pack_exp(input int y, mo, md, wd, h, mi, s);
    return {12'(y < 0 ? 0 : 0), bcd(y), 7'(bcd(s)), 7'(bcd(mi)), 6'(bcd(h)),
            3'(wd), 6'(bcd(md)), 5'(bcd(mo))};
  endfunction

  task automatic check_time(input string req, input int y, mo, md, wd, h, mi, s);
    logic [63:0] act;
    act = {12'h000, year, sec, min, hour, wday, mday, mon};
    check(act == pack_exp(y, mo, md, wd, h, mi, s), req, "fields", act,
          pack_exp(y, mo, md, wd, h, mi, s));
  endtask

  task automatic write_field(input int sel, input logic [11:0] data);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Restart the prescaler and load all fields on edges 1..7 after enable.
  task automatic load(input int y, mo, md, wd, h, mi, s);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    write_field(0, bcd(s));
    write_field(1, bcd(mi));
    write_field(2, bcd(h));
    write_field(3, 12'(wd));
    write_field(4, bcd(md));
    write_field(5, bcd(mo));
    write_field(6, bcd(y));
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 200);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    int y, m, len, t;
    int years [8] = '{0, 1, 4, 96, 100, 200, 400, 999};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check_time("R11", 0, 1, 1, 0, 0, 0, 0);
    check(tick == 1'b0, "R11", "tick", 64'(tick), 0);

    // R1 first strobe after enable, width and period
    @(negedge clk); en = 1'b1;
    wait_tick(n);
    check(n == REF, "R1", "first strobe edge", 64'(n), 64'(REF));
    check_time("R2", 0, 1, 1, 0, 0, 0, 1);
    @(negedge clk);
    check(tick == 1'b0, "R1", "pulse width", 64'(tick), 0);
    wait_tick(n);
    check(n == REF - 1, "R1", "period", 64'(n + 1), 64'(REF));
    // Disable mid-count: prescaler restarts from zero.
    repeat (5) @(negedge clk);
    en = 1'b0;
    repeat (7) begin
      @(negedge clk);
      check(tick == 1'b0, "R1", "no strobe while off", 64'(tick), 0);
    end
    en = 1'b1;
    wait_tick(n);
    check(n == REF, "R1", "restart after disable", 64'(n), 64'(REF));

    // R9 writes ignored while disabled
    @(negedge clk); en = 1'b0;
    write_field(0, 12'h033);
    write_field(6, 12'h777);
    @(negedge clk);
    check_time("R9", 0, 1, 1, 0, 0, 0, 3);

    // R8 field loads, R10 read port
    load(123, 7, 15, 4, 9, 41, 27);
    en = 1'b0;
    @(negedge clk);
    check_time("R8", 123, 7, 15, 4, 9, 41, 27);
    begin
      logic [11:0] exp_rd [8];
      exp_rd = '{bcd(27), bcd(41), bcd(9), 12'd4, bcd(15), bcd(7), bcd(123), 12'h000};
      for (int i = 0; i < 8; i++) begin
        rd_sel = 3'(i);
        #1;
        check(rd_data == exp_rd[i], "R10", "read mux", 64'(rd_data), 64'(exp_rd[i]));
      end
    end

    // R8 write beats the strobe advance of the same field only
    load(5, 3, 10, 2, 8, 30, 10);
    repeat (8) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 12'h040;
    @(negedge clk);
    wr_en = 1'b0;
    check(tick == 1'b1, "R8", "strobe with write", 64'(tick), 1);
    check_time("R8", 5, 3, 10, 2, 8, 40, 11);

    // R7 day 00 becomes 01 without month advance
    load(4, 5, 0, 1, 23, 59, 59);
    wait_tick(n);
    check_time("R7", 4, 5, 1, 2, 0, 0, 0);

    // R4 invalid month values get 31 days, then wrap
    load(10, 0, 30, 0, 23, 59, 59);
    wait_tick(n);
    check_time("R4", 10, 0, 31, 1, 0, 0, 0);
    load(10, 0, 31, 0, 23, 59, 59);
    wait_tick(n);
    check_time("R4", 10, 1, 1, 1, 0, 0, 0);
    load(10, 13, 31, 6, 23, 59, 59);
    wait_tick(n);
    check_time("R5", 11, 1, 1, 0, 0, 0, 0);

    // R4 R5 R6 month length sweep over leap, century and wrap years
    foreach (years[k]) begin
      y = years[k];
      for (m = 1; m <= 12; m++) begin
        len = days_in(m, y);
        load(y, m, len - 1, 3, 23, 59, 59);
        wait_tick(n);
        check_time("R6", y, m, len, 4, 0, 0, 0);
        load(y, m, len, 6, 23, 59, 59);
        wait_tick(n);
        if (m == 12) check_time("R5", (y + 1) % 1000, 1, 1, 0, 0, 0, 0);
        else         check_time("R4", y, m + 1, 1, 0, 0, 0, 0);
      end
    end

    // R2 R3 R5 continuous count from 23:00:00 through the year wrap
    load(999, 12, 31, 5, 23, 0, 0);
    wait_tick(n);
    for (int i = 1; i <= 3700; i++) begin
      if (i > 1) begin
        wait_tick(n);
        check(n == REF, "R1", "steady period", 64'(n), 64'(REF));
      end
      t = 23 * 3600 + i;
      if (t < 86400)
        check_time("R2", 999, 12, 31, 5, t / 3600, (t / 60) % 60, t % 60);
      else begin
        t = t - 86400;
        check_time("R3", 0, 1, 1, 6, t / 3600, (t / 60) % 60, t % 60);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule